// File: doc/BRIEF.md
# Vectored Priority Interrupt Nesting Unit

This unit sits between a bank of interrupt sources and a processor's interrupt entry. Sixteen programmable vector slots each bind one interrupt source number to a handler address. Slot 0 has the highest priority. A default handler address serves any request that no enabled slot claims. Priority here is a nesting level, not a one-shot choice. The unit holds a current service level. It raises its interrupt request only for masked sources that an enabled slot of strictly higher priority claims. Above the idle level, any masked source counts.

When the processor enters a handler, it pulses the acknowledge strobe. The unit then picks the highest-priority pending slot that outranks the current level. It saves the old level in a record kept for the new level, moves to the new level, and presents that level's handler address on the following cycle. When a handler finishes, it pulses the end-of-service strobe. The level saved for the current level is then restored, so nested handlers unwind in reverse order. A synchronous configuration port writes slot addresses, slot control bytes and the default address. The priority masks are derived from the slot control bytes at all times.

Top module: `vic_nest_unit`

## Requirements
- R1: After reset the current level is idle (17). All slot addresses, all slot control bytes and the default address are zero, and `vec_addr` is zero.
- R2: A slot control byte (cfg_kind 1) enables its slot with bit 5 and names the source number in bits 4:0. A disabled slot claims no source.
- R3: The mask for level i is the union of the source bits of enabled slots numbered below i. Level 16 covers every enabled slot, and the idle level 17 admits every source.
- R4: `irq_out` is high exactly when `irq_masked` shares a set bit with the mask of the current level. It reflects a configuration write or a level change from the cycle after the triggering edge.
- R5: On `ack_rd` the unit selects the lowest level i below the current level for which `src_raw` meets the mask of level i+1. It saves the old level for level i and enters level i. From the next cycle `vec_addr` shows slot i's address, or the default address when i is 16.
- R6: On `ack_rd` with no qualifying level, the level is unchanged and `vec_addr` shows the address of the current level. When idle, this is the default address.
- R7: On `eos_wr` below the idle level, the level saved for the current level is restored. At the idle level `eos_wr` has no effect.
- R8: When two enabled slots name the same source, the lower-numbered slot takes that source.
- R9: An acknowledge in the same cycle as a configuration write uses the slot addresses and masks from before the write.
- R10: When `ack_rd` and `eos_wr` coincide, the acknowledge is performed and the end-of-service pulse is discarded.
- R11: `vec_addr` changes only on the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_masked | input | NUM_SRC | Sources after enable and routing masks, used for `irq_out` |
| src_raw | input | NUM_SRC | Unmasked pending sources, used by the acknowledge scan |
| ack_rd | input | 1 | Single-cycle acknowledge (handler entry) strobe |
| eos_wr | input | 1 | Single-cycle end-of-service strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 slot address, 1 slot control byte, 2 default address, 3 ignored |
| cfg_idx | input | log2(NUM_SLOTS) | Slot number for kinds 0 and 1 |
| cfg_wdata | input | ADDR_W | Write data; control byte in the low bits |
| irq_out | output | 1 | Interrupt request toward the processor |
| vec_addr | output | ADDR_W | Handler address latched by the last acknowledge |

## Verification
Two pairs of functions can meet in the same cycle: an acknowledge with a configuration write, and an acknowledge with an end-of-service pulse. The bench provokes each by raising both strobes across a single clock edge. In the first case it rewrites the address of the slot being acknowledged in that same edge, and expects the old address back; a second acknowledge then returns the new one. In the second case it judges the result from the level reached. The returned address must belong to the newly entered level. The interrupt request must follow that level's mask. A single later end-of-service must then return to the level that was active before the coincident pulse.

// File: rtl/vnu_pkg.sv
package vnu_pkg;
  typedef enum logic [1:0] {
    CFG_SLOT_ADDR = 2'd0,
    CFG_SLOT_CTRL = 2'd1,
    CFG_DEF_ADDR  = 2'd2,
    CFG_NONE      = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/vnu_mask_gen.sv
module vnu_mask_gen #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_SRC   = 32,
  parameter int SEL_W     = 5,
  parameter int CTRL_W    = SEL_W + 1,
  parameter int NLVL      = NUM_SLOTS + 1
) (
  input  logic [NUM_SLOTS-1:0][CTRL_W-1:0] slot_ctrl,
  output logic [NLVL:0][NUM_SRC-1:0]       lvl_mask
);
  // one-hot source claimed by a slot, zero when the slot is disabled
  function automatic logic [NUM_SRC-1:0] slot_onehot(input logic [CTRL_W-1:0] c);
    logic [NUM_SRC-1:0] v;
    v = '0;
    if (c[SEL_W]) v[c[SEL_W-1:0]] = 1'b1;
    return v;
  endfunction

  assign lvl_mask[0] = '0;
  for (genvar i = 1; i <= NUM_SLOTS; i++) begin : g_cum
    assign lvl_mask[i] = lvl_mask[i-1] | slot_onehot(slot_ctrl[i-1]);
  end
  assign lvl_mask[NLVL] = '1;
endmodule

// File: rtl/vnu_arbiter.sv
module vnu_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int NLVL    = 17,
  parameter int LVL_W   = 5
) (
  input  logic [NUM_SRC-1:0]         src_raw,
  input  logic [NLVL:0][NUM_SRC-1:0] lvl_mask,
  input  logic [LVL_W-1:0]           cur_lvl,
  output logic                       hit,
  output logic [LVL_W-1:0]           hit_lvl
);
  // descending walk so that the lowest qualifying level is the one kept
  always_comb begin
    hit     = 1'b0;
    hit_lvl = cur_lvl;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if ((LVL_W'(i) < cur_lvl) && (|(src_raw & lvl_mask[i+1]))) begin
        hit     = 1'b1;
        hit_lvl = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/vnu_nest_rec.sv
module vnu_nest_rec #(
  parameter int NLVL  = 17,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic             eos,
  input  logic             hit,
  input  logic [LVL_W-1:0] hit_lvl,
  output logic [LVL_W-1:0] cur_lvl
);
  localparam logic [LVL_W-1:0] IDLE = LVL_W'(NLVL);

  logic [LVL_W-1:0] prev_lvl [NLVL];
  logic ack_taken;
  logic eos_taken;

  assign ack_taken = ack & hit;
  assign eos_taken = eos & ~ack & (cur_lvl != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_lvl <= IDLE;
      for (int k = 0; k < NLVL; k++) prev_lvl[k] <= IDLE;
    end else if (ack_taken) begin
      prev_lvl[hit_lvl] <= cur_lvl;
      cur_lvl           <= hit_lvl;
    end else if (eos_taken) begin
      cur_lvl <= prev_lvl[cur_lvl];
    end
  end

  AST_ACK_RAISE:  assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> cur_lvl <= $past(cur_lvl));                          // R5
  AST_EOS_LOWER:  assert property (@(posedge clk) disable iff (!rst_n)
    eos_taken |=> cur_lvl > $past(cur_lvl));                     // R7
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !eos) |=> $stable(cur_lvl));                        // R7
  AST_COLLIDE:    assert property (@(posedge clk) disable iff (!rst_n)
    (ack && eos && !hit) |=> $stable(cur_lvl));                  // R10
endmodule

// File: rtl/vic_nest_unit.sv
module vic_nest_unit
  import vnu_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_SRC   = 32,
  parameter int ADDR_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           irq_masked,
  input  logic [NUM_SRC-1:0]           src_raw,
  input  logic                         ack_rd,
  input  logic                         eos_wr,
  input  logic                         cfg_we,
  input  logic [1:0]                   cfg_kind,
  input  logic [$clog2(NUM_SLOTS)-1:0] cfg_idx,
  input  logic [ADDR_W-1:0]            cfg_wdata,
  output logic                         irq_out,
  output logic [ADDR_W-1:0]            vec_addr
);
  localparam int SEL_W  = $clog2(NUM_SRC);
  localparam int CTRL_W = SEL_W + 1;
  localparam int NLVL   = NUM_SLOTS + 1;
  localparam int LVL_W  = $clog2(NLVL + 1);
  localparam int IDX_W  = $clog2(NUM_SLOTS);
  localparam logic [LVL_W-1:0] IDLE = LVL_W'(NLVL);

  logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
  logic [NUM_SLOTS-1:0][CTRL_W-1:0] slot_ctrl;
  logic [ADDR_W-1:0]                def_addr;
  logic [NLVL:0][NUM_SRC-1:0]       lvl_mask;
  logic [LVL_W-1:0]                 cur_lvl;
  logic                             hit;
  logic [LVL_W-1:0]                 hit_lvl;
  logic [LVL_W-1:0]                 next_lvl;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_addr <= '0;
      slot_ctrl <= '0;
      def_addr  <= '0;
    end else if (cfg_we) begin
      case (cfg_kind_e'(cfg_kind))
        CFG_SLOT_ADDR: slot_addr[cfg_idx] <= cfg_wdata;
        CFG_SLOT_CTRL: slot_ctrl[cfg_idx] <= cfg_wdata[CTRL_W-1:0];
        CFG_DEF_ADDR:  def_addr           <= cfg_wdata;
        default: ;
      endcase
    end
  end

  vnu_mask_gen #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W),
    .CTRL_W(CTRL_W), .NLVL(NLVL)
  ) u_mask (
    .slot_ctrl(slot_ctrl),
    .lvl_mask (lvl_mask)
  );

  vnu_arbiter #(.NUM_SRC(NUM_SRC), .NLVL(NLVL), .LVL_W(LVL_W)) u_arb (
    .src_raw (src_raw),
    .lvl_mask(lvl_mask),
    .cur_lvl (cur_lvl),
    .hit     (hit),
    .hit_lvl (hit_lvl)
  );

  vnu_nest_rec #(.NLVL(NLVL), .LVL_W(LVL_W)) u_rec (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack    (ack_rd),
    .eos    (eos_wr),
    .hit    (hit),
    .hit_lvl(hit_lvl),
    .cur_lvl(cur_lvl)
  );

  // handler address of a level; default beyond the vectored slots
  function automatic logic [ADDR_W-1:0] lvl_addr(input logic [LVL_W-1:0] l);
    if (l < LVL_W'(NUM_SLOTS)) return slot_addr[l[IDX_W-1:0]];
    return def_addr;
  endfunction

  assign next_lvl = hit ? hit_lvl : cur_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n)      vec_addr <= '0;
    else if (ack_rd) vec_addr <= lvl_addr(next_lvl);
  end

  assign irq_out = |(irq_masked & lvl_mask[cur_lvl]);

  AST_VEC_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
    !ack_rd |=> $stable(vec_addr));                              // R11
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_masked == '0) |-> !irq_out);                            // R4
  AST_IDLE_ANY:  assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == IDLE) |-> (irq_out == (|irq_masked)));           // R3
endmodule

// File: tb/test_vic_nest_unit.sv
module test_vic_nest_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 6;
  // table: source vector, expected level after acknowledge from idle, expected address
  localparam logic [31:0] TV_SRC  [NT] = '{32'h0000_1000, 32'h0000_0080, 32'h0000_0200,
                                           32'h0000_1008, 32'h0000_0000, 32'h0010_0000};
  localparam int          TV_LVL  [NT] = '{4, 1, 16, 0, 17, 16};
  localparam logic [31:0] TV_ADDR [NT] = '{32'h1040, 32'h1010, 32'hDEF0,
                                           32'h1000, 32'hDEF0, 32'hDEF0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_masked = '0;
  logic [31:0] src_raw = '0;
  logic        ack_rd = 1'b0;
  logic        eos_wr = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        irq_out;
  logic [31:0] vec_addr;

  int checks = 0;
  int failures = 0;
  logic [7:0] bctrl [16];

  vic_nest_unit i_vic_nest_unit (
    .clk(clk), .rst_n(rst_n), .irq_masked(irq_masked), .src_raw(src_raw),
    .ack_rd(ack_rd), .eos_wr(eos_wr), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .irq_out(irq_out), .vec_addr(vec_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected request: level-mask rule restated from the slot table the bench wrote
  function automatic logic exp_irq(input logic [31:0] m, input int lvl);
    logic [31:0] mk;
    mk = '0;
    if (lvl >= 17) return |m;
    for (int k = 0; k < lvl; k++) if (bctrl[k][5]) mk[bctrl[k][4:0]] = 1'b1;
    return |(m & mk);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask
  task automatic set_src(input logic [31:0] v);
    src_raw = v; irq_masked = v; tick();
  endtask
  task automatic do_ack();
    ack_rd = 1'b1; tick(); ack_rd = 1'b0;
  endtask
  task automatic do_eos();
    eos_wr = 1'b1; tick(); eos_wr = 1'b0;
  endtask
  task automatic cfg(input logic [1:0] k, input int idx, input logic [31:0] d);
    cfg_we = 1'b1; cfg_kind = k; cfg_idx = 4'(idx); cfg_wdata = d;
    tick(); cfg_we = 1'b0;
    if (k == 2'd1) bctrl[idx] = d[7:0];
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) bctrl[k] = 8'h00;
    tick(); tick(); rst_n = 1'b1; tick();
    // R1 reset state
    chk("R1 vec_addr after reset", vec_addr, 32'h0);
    chk("R1 irq quiet after reset", {31'b0, irq_out}, 32'h0);
    set_src(32'h20);
    chk("R3 idle admits any source", {31'b0, irq_out}, 32'h1);
    do_ack();
    chk("R1 default address zero", vec_addr, 32'h0);
    chk("R2 no slot enabled, level16 quiet", {31'b0, irq_out}, 32'h0);
    do_eos();
    chk("R7 restore to idle", {31'b0, irq_out}, 32'h1);
    set_src(32'h0);

    // program slots: 0->src3, 1->src7, 2 disabled src9, 3->src7, 4->src12
    for (int k = 0; k < 16; k++) cfg(2'd0, k, 32'h1000 + 32'(k) * 32'h10);
    cfg(2'd2, 0, 32'hDEF0);
    cfg(2'd1, 0, 32'h23);
    cfg(2'd1, 1, 32'h27);
    cfg(2'd1, 2, 32'h09);
    cfg(2'd1, 3, 32'h27);
    cfg(2'd1, 4, 32'h2C);

    // table walk: R5, R6, R8 (entry 1 is the duplicated source), R2 (entry 2)
    for (int t = 0; t < NT; t++) begin
      set_src(TV_SRC[t]);
      do_ack();
      chk("R5 R6 R8 table address", vec_addr, TV_ADDR[t]);
      chk("R4 table irq at new level", {31'b0, irq_out}, {31'b0, exp_irq(TV_SRC[t], TV_LVL[t])});
      if (TV_LVL[t] != 17) do_eos();
      chk("R7 table back to idle", {31'b0, irq_out}, {31'b0, exp_irq(TV_SRC[t], 17)});
    end

    // nesting at two levels, restores in reverse order
    set_src(32'h1000);
    do_ack();
    chk("R5 nest outer address", vec_addr, 32'h1040);
    set_src(32'h1008);
    chk("R4 higher source requests at level4", {31'b0, irq_out}, 32'h1);
    do_ack();
    chk("R5 nest inner address", vec_addr, 32'h1000);
    chk("R4 level0 masks all", {31'b0, irq_out}, 32'h0);
    do_ack();
    chk("R6 repeat ack keeps level0", vec_addr, 32'h1000);
    do_eos();
    chk("R7 restore to level4", {31'b0, irq_out}, 32'h1);
    set_src(32'h1000);
    do_eos();
    chk("R7 restore to idle", {31'b0, irq_out}, 32'h1);
    do_eos();
    chk("R7 eos at idle no effect", {31'b0, irq_out}, 32'h1);
    do_ack();
    chk("R7 still idle before ack", vec_addr, 32'h1040);

    // ack and eos together at level4: ack wins
    set_src(32'h1080);
    ack_rd = 1'b1; eos_wr = 1'b1; tick(); ack_rd = 1'b0; eos_wr = 1'b0;
    chk("R10 coincident ack taken", vec_addr, 32'h1010);
    chk("R10 level1 mask", {31'b0, irq_out}, {31'b0, exp_irq(32'h1080, 1)});
    do_eos();
    chk("R10 single eos returns to level4", {31'b0, irq_out}, {31'b0, exp_irq(32'h1080, 4)});
    do_eos();
    chk("R11 address held without ack", vec_addr, 32'h1010);

    // ack with config write in the same cycle
    set_src(32'h1000);
    ack_rd = 1'b1; cfg_we = 1'b1; cfg_kind = 2'd0; cfg_idx = 4'd4; cfg_wdata = 32'h5555;
    tick(); ack_rd = 1'b0; cfg_we = 1'b0;
    chk("R9 ack uses pre-write address", vec_addr, 32'h1040);
    do_ack();
    chk("R6 current level address after rewrite", vec_addr, 32'h5555);
    do_eos();

    // mask recomputed by a control write while at level16
    set_src(32'h200);
    do_ack();
    chk("R2 disabled slot ignored", vec_addr, 32'hDEF0);
    chk("R4 level16 quiet before enable", {31'b0, irq_out}, 32'h0);
    cfg(2'd1, 2, 32'h29);
    chk("R4 irq after control write", {31'b0, irq_out}, 32'h1);
    do_eos();
    do_ack();
    chk("R2 enabled slot2 claims source9", vec_addr, 32'h1020);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule